// File: doc/BRIEF.md
# Pin Expander Register Bank

This block is the register core of a 16-pin bidirectional port controller. It holds eight byte-wide registers, grouped four kinds by two 8-pin ports: a sampled input view, a latched output value, a polarity mask applied to the input view, and a direction mask. A host reaches them through a byte write stream and a read request/response pair. A write beat flagged as a command sets an internal register pointer. Unflagged data beats, and every read, then act on the register that pointer selects.

Register index = kind × 2 + port. Port 0 takes the even index of each pair. Kind order: 0 input view, 1 output value, 2 polarity mask, 3 direction mask, so indices 0..7 map in[0], in[1], out[0], out[1], pol[0], pol[1], dir[0], dir[1]. Per pin, the block drives a value and an enable toward a tristate pad and samples the pad level back. The sampled level passes a two-flop synchronizer before it is used.

Write stream: `wr_ready` is tied high, so every cycle with `wr_valid` high consumes one beat. Read path: a request is taken on a cycle where `rq_valid` and `rq_ready` are both high. The selected register is latched into `rd_data`, and `rd_valid` rises on the next cycle. `rd_valid` and `rd_data` hold until a cycle with `rd_ready` high. `rq_ready` is `!rd_valid || rd_ready`, so a stalled response blocks new requests.

Top module: `pinbank_regs`

## Requirements
- R1: After reset both output value registers read 0xFF, both polarity masks read 0x00 and both direction masks read 0xFF. All pad enables are low and all pad values are high.
- R2: A command beat (`wr_cmd`=1) loads `wr_data` into the pointer. A data beat (`wr_cmd`=0) writes the register at the pointer. A read returns the register at the pointer, with indices 2/3 output, 4/5 polarity and 6/7 direction for ports 0/1.
- R3: A data beat while the pointer is 0 or 1 changes no register and no pad output.
- R4: Reading index 0 or 1 returns the synchronized pad level of every pin of that port, including pins configured as outputs.
- R5: A polarity mask bit of 1 inverts that pin in the input view. A bit of 0 passes the pin through unchanged.
- R6: Reading index 2 or 3 returns the stored output value, not the pad level.
- R7: A direction bit of 1 drives the pad enable low, so the output value has no effect on that pad. A direction bit of 0 drives the enable high, and the pad follows the output value.
- R8: The pointer keeps its value until the next command beat, so repeated reads return the same register.
- R9: With a pointer of 8 or more, data beats change nothing and reads return 0x00.
- R10: A pad change is not seen by a read taken at the next clock edge. A read taken three edges later sees it.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` stays stable and `rq_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_cmd | input | 1 | Beat is a command byte that loads the pointer |
| wr_data | input | 8 | Write beat byte |
| rq_valid | input | 1 | Read request |
| rq_ready | output | 1 | Read request can be taken |
| rd_valid | output | 1 | Read response present |
| rd_ready | input | 1 | Host takes the response |
| rd_data | output | 8 | Read response byte |
| pad_in | input | 16 | Sampled pad levels |
| pad_out | output | 16 | Per-pin output value |
| pad_oe | output | 16 | Per-pin output enable |

## Verification
The bench builds the block with its defaults: two ports and a two-stage synchronizer. The full index space 0..7, plus out-of-range pointers, is therefore reachable by directed writes. The two-stage depth makes the exact edge at which a pad change appears in a read predictable, so the first stale read and the later fresh read can both be checked. Pads are modelled as resolved tristate nets with bench drivers on released pins. This allows loopback reads on output pins and checks that the latched output value has no effect on input pins.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int BYTE_W = 8;
  localparam int KINDS  = 4;

  typedef enum logic [1:0] {
    RK_IN  = 2'd0,
    RK_OUT = 2'd1,
    RK_POL = 2'd2,
    RK_DIR = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_lvl,
  input  logic              we_out,
  input  logic              we_pol,
  input  logic              we_dir,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] in_view,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] pol_q,
  output logic [BYTE_W-1:0] dir_q,
  output logic [BYTE_W-1:0] drv_val,
  output logic [BYTE_W-1:0] drv_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else begin
      if (we_out) out_q <= wdata;
      if (we_pol) pol_q <= wdata;
      if (we_dir) dir_q <= wdata;
    end
  end

  assign in_view = pin_lvl ^ pol_q;
  assign drv_val = out_q;
  assign drv_en  = ~dir_q;

  p_reset_vals_r1: assert property (@(posedge clk)
    !rst_n |=> (out_q == '1 && pol_q == '0 && dir_q == '1));
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int PORTS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic                      wr_cmd,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic                      rq_valid,
  output logic                      rq_ready,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [BYTE_W-1:0]         rd_data,
  input  logic [PORTS*BYTE_W-1:0]   pad_in,
  output logic [PORTS*BYTE_W-1:0]   pad_out,
  output logic [PORTS*BYTE_W-1:0]   pad_oe
);
  localparam int NPIN = PORTS * BYTE_W;
  localparam int NREG = KINDS * PORTS;

  logic [BYTE_W-1:0] ptr_q;
  logic [BYTE_W-1:0] ptr_kind_idx, ptr_port;
  reg_kind_e         ptr_kind;
  logic              ptr_ok;
  logic              data_wr, rq_fire;
  logic [NPIN-1:0]   pin_sync;
  logic [BYTE_W-1:0] sel_byte;

  logic [BYTE_W-1:0] v_in  [PORTS];
  logic [BYTE_W-1:0] v_out [PORTS];
  logic [BYTE_W-1:0] v_pol [PORTS];
  logic [BYTE_W-1:0] v_dir [PORTS];

  assign wr_ready     = 1'b1;
  assign data_wr      = wr_valid && !wr_cmd;
  assign ptr_ok       = ptr_q < BYTE_W'(NREG);
  assign ptr_kind_idx = ptr_q / BYTE_W'(PORTS);
  assign ptr_port     = ptr_q % BYTE_W'(PORTS);
  assign ptr_kind     = reg_kind_e'(ptr_kind_idx[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (wr_valid && wr_cmd) ptr_q <= wr_data;
  end

  pinbank_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pad_in),
    .q_sync (pin_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic hit;
    assign hit = data_wr && ptr_ok && (ptr_port == BYTE_W'(p));

    pinbank_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_lvl(pin_sync[p*BYTE_W +: BYTE_W]),
      .we_out (hit && ptr_kind == RK_OUT),
      .we_pol (hit && ptr_kind == RK_POL),
      .we_dir (hit && ptr_kind == RK_DIR),
      .wdata  (wr_data),
      .in_view(v_in[p]),
      .out_q  (v_out[p]),
      .pol_q  (v_pol[p]),
      .dir_q  (v_dir[p]),
      .drv_val(pad_out[p*BYTE_W +: BYTE_W]),
      .drv_en (pad_oe[p*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (ptr_ok && ptr_port == BYTE_W'(p)) begin
        unique case (ptr_kind)
          RK_IN:  sel_byte = v_in[p];
          RK_OUT: sel_byte = v_out[p];
          RK_POL: sel_byte = v_pol[p];
          RK_DIR: sel_byte = v_dir[p];
        endcase
      end
    end
  end

  assign rq_ready = !rd_valid || rd_ready;
  assign rq_fire  = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rq_fire) begin
      rd_valid <= 1'b1;
      rd_data  <= sel_byte;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  p_input_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr_q < BYTE_W'(PORTS)) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_ptr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_cmd) |=> $stable(ptr_q));

  p_bad_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_fire && !(ptr_q < BYTE_W'(NREG))) |=> (rd_data == '0));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/sim_pinbank_regs.sv
module sim_pinbank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_cmd = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rq_valid = 1'b0, rd_ready = 1'b1;
  logic        wr_ready, rq_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [15:0] pad_in, pad_out, pad_oe;
  logic [15:0] ext_en = '0, ext_val = '0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < 16; i++)
      pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : 1'b1);

  pinbank_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cmd(wr_cmd), .wr_data(wr_data), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_cmd = c; wr_data = d;
    @(posedge clk); #1; wr_valid = 1'b0; wr_cmd = 1'b0;
  endtask

  task automatic get(output logic [7:0] d);
    @(negedge clk); rq_valid = 1'b1;
    @(posedge clk); #1; rq_valid = 1'b0; d = rd_data;
  endtask

  task automatic read_idx(input logic [7:0] idx, output logic [7:0] d);
    put(1'b1, idx);
    get(d);
  endtask

  task automatic set_idx(input logic [7:0] idx, input logic [7:0] v);
    put(1'b1, idx);
    put(1'b0, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(pad_oe == 16'h0000, "R1 oe", pad_oe, 16'h0000);
    chk(pad_out == 16'hFFFF, "R1 out", pad_out, 16'hFFFF);
    for (int i = 2; i < 8; i++) begin
      read_idx(8'(i), d);
      chk(d == ((i == 4 || i == 5) ? 8'h00 : 8'hFF), "R1 reg", {8'h0, d},
          (i == 4 || i == 5) ? 16'h0000 : 16'h00FF);
    end
  endtask

  task automatic t_rw;
    logic [7:0] d;
    set_idx(8'd2, 8'hA5); read_idx(8'd2, d); chk(d == 8'hA5, "R2 out0", {8'h0, d}, 16'h00A5);
    set_idx(8'd3, 8'h5A); read_idx(8'd3, d); chk(d == 8'h5A, "R2 out1", {8'h0, d}, 16'h005A);
    set_idx(8'd5, 8'h0F); read_idx(8'd5, d); chk(d == 8'h0F, "R2 pol1", {8'h0, d}, 16'h000F);
    set_idx(8'd5, 8'h00);
    set_idx(8'd6, 8'h00); read_idx(8'd6, d); chk(d == 8'h00, "R2 dir0", {8'h0, d}, 16'h0000);
    chk(pad_oe == 16'h00FF, "R7 oe", pad_oe, 16'h00FF);
    chk(pad_in[7:0] == 8'hA5, "R7 pad follows", {8'h0, pad_in[7:0]}, 16'h00A5);
  endtask

  task automatic t_ro;
    logic [7:0] d;
    logic [15:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    set_idx(8'd0, 8'h3C);
    set_idx(8'd1, 8'h00);
    chk(pad_oe == oe0 && pad_out == out0, "R3 pads", pad_out, out0);
    read_idx(8'd3, d); chk(d == 8'h5A, "R3 out1 kept", {8'h0, d}, 16'h005A);
    read_idx(8'd4, d); chk(d == 8'h00, "R3 pol0 kept", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_loop;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    read_idx(8'd0, d);
    chk(d == 8'hA5, "R4 loopback", {8'h0, d}, 16'h00A5);
  endtask

  task automatic t_pol;
    logic [7:0] d;
    ext_en[15:8] = 8'hFF; ext_val[15:8] = 8'h3C;
    set_idx(8'd5, 8'hFF);
    repeat (3) @(negedge clk);
    read_idx(8'd1, d); chk(d == 8'hC3, "R5 invert all", {8'h0, d}, 16'h00C3);
    set_idx(8'd5, 8'h0F);
    read_idx(8'd1, d); chk(d == 8'h33, "R5 invert low", {8'h0, d}, 16'h0033);
    set_idx(8'd5, 8'h00);
  endtask

  task automatic t_outread;
    logic [7:0] d;
    ext_val[15:8] = 8'h00;
    set_idx(8'd3, 8'hFF);
    repeat (3) @(negedge clk);
    read_idx(8'd3, d); chk(d == 8'hFF, "R6 latched", {8'h0, d}, 16'h00FF);
    chk(pad_in[15:8] == 8'h00, "R7 no effect", {8'h0, pad_in[15:8]}, 16'h0000);
    chk(pad_oe[15:8] == 8'h00, "R7 released", pad_oe, 16'h00FF);
  endtask

  task automatic t_ptr;
    logic [7:0] d1, d2;
    set_idx(8'd4, 8'h96);
    get(d1); get(d2);
    chk(d1 == 8'h96 && d2 == 8'h96, "R8 repeat", {d1, d2}, 16'h9696);
  endtask

  task automatic t_bad;
    logic [7:0] d;
    logic [15:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    set_idx(8'd9, 8'h00);
    get(d); chk(d == 8'h00, "R9 read zero", {8'h0, d}, 16'h0000);
    chk(pad_oe == oe0 && pad_out == out0, "R9 pads", pad_oe, oe0);
    read_idx(8'd4, d); chk(d == 8'h96, "R9 pol0 kept", {8'h0, d}, 16'h0096);
    read_idx(8'd7, d); chk(d == 8'hFF, "R9 dir1 kept", {8'h0, d}, 16'h00FF);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    put(1'b1, 8'd1);
    repeat (3) @(negedge clk);
    @(negedge clk); ext_val[15:8] = 8'hFF; rq_valid = 1'b1;
    @(posedge clk); #1; rq_valid = 1'b0; d = rd_data;
    chk(d == 8'h00, "R10 stale", {8'h0, d}, 16'h0000);
    repeat (2) @(negedge clk);
    get(d);
    chk(d == 8'hFF, "R10 fresh", {8'h0, d}, 16'h00FF);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    put(1'b1, 8'd2);
    rd_ready = 1'b0;
    get(d);
    put(1'b1, 8'd6);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rd_valid && !rq_ready && rd_data == d, "R11 hold", {8'h0, rd_data}, {8'h0, d});
    end
    rd_ready = 1'b1;
    @(posedge clk); #1;
    chk(!rd_valid, "R11 drain", {15'h0, rd_valid}, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_rw; t_ro; t_loop; t_pol; t_outread; t_ptr; t_bad; t_sync; t_hold;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule